// File: doc/BRIEF.md
# Hierarchical Cost Pyramid Accumulator

This block turns a stream of finest-scale matching costs into a four-level pyramid of coarser costs, as used by coarse-to-fine belief-propagation stereo engines. Each input element is one cost for one pixel and one disparity state. The element carries its column, line and state index. A stream of level-0 costs goes in. One cost stream per level comes out, each with its own valid flag.

Every coarser level is built from the level below it in two steps. First, the costs of two horizontally neighbouring nodes for the same state are added. The block keeps the left cost of each pair in a small per-state register. Second, the half-row of pair sums from an even line is held in a per-state line store until the odd line below it arrives. The two are then added, which completes the 2×2 block sum. Accumulators widen by two bits per level, so no sum can wrap.

A select input routes one level's stream, together with its position, to a shared output for the processing elements. The same select produces a mask of the elements that are active at that scale in a group of eight.

Top module: `cost_pyramid_acc`

## Requirements
- R1: Level 0 reproduces each input cost on `lvlCost[0]`, with `lvlValid[0]` high, one clock after the input element is accepted (`inValid` high). Element order is unchanged.
- R2: For k = 1..3, the level-k cost of node (x, y) and state s is the sum of the level-(k−1) costs at columns 2x and 2x+1, lines 2y and 2y+1, for the same state s.
- R3: A level-k element is produced only when the level-(k−1) element at an odd column on an odd line arrives. A frame of W×H×S inputs therefore yields exactly (W>>k)·(H>>k)·S level-k elements. They come in raster order with the state index varying fastest.
- R4: The level-k output is CW+2k bits wide and never wraps. An input frame of all-ones costs gives (2^CW−1)·4^k at level k.
- R5: Idle cycles (`inValid` low) anywhere in the stream produce no output element and do not alter any sum.
- R6: `selValid`, `selCost`, `selCol`, `selLine` and `selState` carry the stream of the level named by `lvlSel` (0..3). The position fields give that level's own column, line and state.
- R7: `peMask` has its lowest 8>>`lvlSel` bits set and all other bits clear.
- R8: While `rstN` is low, and in the first cycle after it is released, no valid flag is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Input element present |
| inCost | input | CW | Level-0 matching cost |
| inCol | input | COLW | Column of the input element |
| inLine | input | LINEW | Line of the input element |
| inState | input | SW | Disparity state of the input element |
| lvlSel | input | LSW | Level routed to the select output |
| lvlValid | output | LEVELS | Per-level element valid |
| lvlCost | output | LEVELS×OW | Per-level cost, zero-extended to OW |
| selValid | output | 1 | Selected level's valid |
| selCost | output | OW | Selected level's cost |
| selCol | output | COLW | Selected level's column |
| selLine | output | LINEW | Selected level's line |
| selState | output | SW | Selected level's state |
| peMask | output | GROUP | Active processing elements at the selected level |

## Verification
The bench builds the block with a 16×16 frame, four states and 8-bit costs. This is small enough that a whole frame takes about a thousand cycles. It is still large enough that level 3 has a 2×2 node grid, so the final line-store pairing is exercised more than once. Random cost frames with random idle gaps are mixed with directed frames: all-ones, which reaches the widest sums at every level; all-zero; and a position-coded ramp. Every level and every select value is compared with a pyramid computed in the bench.

// File: rtl/cpa_pkg.sv
package cpa_pkg;
  // per-level control strobes from the controller to the datapath
  typedef struct packed {
    logic hold;   // first of a horizontal pair: park it
    logic store;  // second of pair on an even line: write pair sum to line store
    logic emit;   // second of pair on an odd line: finish the 2x2 sum
  } lvlStrobe_t;
endpackage

// File: rtl/cpa_ctrl.sv
module cpa_ctrl
  import cpa_pkg::*;
#(
  parameter int LEVELS = 4,
  parameter int COLW   = 4,
  parameter int LINEW  = 4,
  parameter int SW     = 2
) (
  input  logic                              clk,
  input  logic                              rstN,
  input  logic                              inValid,
  input  logic [COLW-1:0]                   inCol,
  input  logic [LINEW-1:0]                  inLine,
  input  logic [SW-1:0]                     inState,
  output logic [LEVELS-1:0]                 stageValid,
  output logic [LEVELS-1:0][COLW-1:0]       stageCol,
  output logic [LEVELS-1:0][LINEW-1:0]      stageLine,
  output logic [LEVELS-1:0][SW-1:0]         stageState,
  output lvlStrobe_t [LEVELS-1:0]           strobe
);

  always_comb begin
    strobe[0] = '0;
    for (int k = 1; k < LEVELS; k++) begin
      strobe[k].hold  = stageValid[k-1] & ~stageCol[k-1][0];
      strobe[k].store = stageValid[k-1] &  stageCol[k-1][0] & ~stageLine[k-1][0];
      strobe[k].emit  = stageValid[k-1] &  stageCol[k-1][0] &  stageLine[k-1][0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stageValid <= '0;
    end else begin
      stageValid[0] <= inValid;
      for (int k = 1; k < LEVELS; k++) stageValid[k] <= strobe[k].emit;
    end
  end

  always_ff @(posedge clk) begin
    if (inValid) begin
      stageCol[0]   <= inCol;
      stageLine[0]  <= inLine;
      stageState[0] <= inState;
    end
    for (int k = 1; k < LEVELS; k++) begin
      if (strobe[k].emit) begin
        stageCol[k]   <= stageCol[k-1] >> 1;
        stageLine[k]  <= stageLine[k-1] >> 1;
        stageState[k] <= stageState[k-1];
      end
    end
  end

  // R8: nothing valid in the cycle after a reset edge
  a_r8_reset_quiet: assert property (@(posedge clk) !rstN |=> stageValid == '0);

  generate
    for (genvar k = 1; k < LEVELS; k++) begin : g_chk
      // R3: a coarse element always follows an element of the level below
      a_r3_follows_lower: assert property (@(posedge clk) disable iff (!rstN)
        stageValid[k] |-> $past(stageValid[k-1]));
      // R2: the three strobes of a level never coincide
      a_r2_strobe_excl: assert property (@(posedge clk) disable iff (!rstN)
        $onehot0({strobe[k].hold, strobe[k].store, strobe[k].emit}));
    end
  endgenerate

endmodule

// File: rtl/cpa_dp.sv
module cpa_dp
  import cpa_pkg::*;
#(
  parameter int LEVELS = 4,
  parameter int CW     = 8,
  parameter int COLW   = 4,
  parameter int SW     = 2,
  localparam int OW    = CW + 2*(LEVELS-1)
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          inValid,
  input  logic [CW-1:0]                 inCost,
  input  lvlStrobe_t [LEVELS-1:0]       strobe,
  input  logic [LEVELS-1:0]             stageValid,
  input  logic [LEVELS-1:0][COLW-1:0]   stageCol,
  input  logic [LEVELS-1:0][SW-1:0]     stageState,
  output logic [LEVELS-1:0][OW-1:0]     lvlCost
);

  logic [CW-1:0] baseReg;

  always_ff @(posedge clk) begin
    if (inValid) baseReg <= inCost;
  end

  assign lvlCost[0] = OW'(baseReg);

  generate
    for (genvar k = 1; k < LEVELS; k++) begin : g_lvl
      localparam int IW = CW + 2*(k-1);   // width of the level below
      localparam int HW = IW + 1;         // pair sum width
      localparam int RW = IW + 2;         // block sum width
      localparam int LW = COLW - k;       // line-store index bits
      localparam logic [OW-1:0] LIMIT = OW'(((1 << CW) - 1) << (2*k));

      logic [IW-1:0] pairReg [2**SW];
      logic [HW-1:0] lineStore [2**LW][2**SW];
      logic [RW-1:0] blockReg;
      logic [SW-1:0] sIdx;
      logic [LW-1:0] cIdx;
      logic [IW-1:0] below;
      logic [HW-1:0] pairSum;

      assign sIdx    = stageState[k-1];
      assign cIdx    = stageCol[k-1][LW:1];
      assign below   = lvlCost[k-1][IW-1:0];
      assign pairSum = {1'b0, pairReg[sIdx]} + {1'b0, below};

      always_ff @(posedge clk) begin
        if (strobe[k].hold)  pairReg[sIdx] <= below;
        if (strobe[k].store) lineStore[cIdx][sIdx] <= pairSum;
        if (strobe[k].emit)  blockReg <= {1'b0, lineStore[cIdx][sIdx]} + {1'b0, pairSum};
      end

      assign lvlCost[k] = OW'(blockReg);

      // R4: a level-k sum never exceeds four^k times the largest input
      a_r4_no_overflow: assert property (@(posedge clk) disable iff (!rstN)
        stageValid[k] |-> lvlCost[k] <= LIMIT);
    end
  endgenerate

endmodule

// File: rtl/cost_pyramid_acc.sv
module cost_pyramid_acc
  import cpa_pkg::*;
#(
  parameter int WIDTH  = 16,
  parameter int HEIGHT = 16,
  parameter int STATES = 4,
  parameter int CW     = 8,
  parameter int LEVELS = 4,
  parameter int GROUP  = 8,
  localparam int COLW  = $clog2(WIDTH),
  localparam int LINEW = $clog2(HEIGHT),
  localparam int SW    = $clog2(STATES),
  localparam int LSW   = $clog2(LEVELS),
  localparam int OW    = CW + 2*(LEVELS-1)
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       inValid,
  input  logic [CW-1:0]              inCost,
  input  logic [COLW-1:0]            inCol,
  input  logic [LINEW-1:0]           inLine,
  input  logic [SW-1:0]              inState,
  input  logic [LSW-1:0]             lvlSel,
  output logic [LEVELS-1:0]          lvlValid,
  output logic [LEVELS-1:0][OW-1:0]  lvlCost,
  output logic                       selValid,
  output logic [OW-1:0]              selCost,
  output logic [COLW-1:0]            selCol,
  output logic [LINEW-1:0]           selLine,
  output logic [SW-1:0]              selState,
  output logic [GROUP-1:0]           peMask
);

  lvlStrobe_t [LEVELS-1:0]          strobe;
  logic [LEVELS-1:0]                stageValid;
  logic [LEVELS-1:0][COLW-1:0]      stageCol;
  logic [LEVELS-1:0][LINEW-1:0]     stageLine;
  logic [LEVELS-1:0][SW-1:0]        stageState;

  cpa_ctrl #(.LEVELS(LEVELS), .COLW(COLW), .LINEW(LINEW), .SW(SW)) u_ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inCol(inCol), .inLine(inLine),
    .inState(inState), .stageValid(stageValid), .stageCol(stageCol),
    .stageLine(stageLine), .stageState(stageState), .strobe(strobe)
  );

  cpa_dp #(.LEVELS(LEVELS), .CW(CW), .COLW(COLW), .SW(SW)) u_dp (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inCost(inCost), .strobe(strobe),
    .stageValid(stageValid), .stageCol(stageCol), .stageState(stageState),
    .lvlCost(lvlCost)
  );

  assign lvlValid = stageValid;
  assign selValid = stageValid[lvlSel];
  assign selCost  = lvlCost[lvlSel];
  assign selCol   = stageCol[lvlSel];
  assign selLine  = stageLine[lvlSel];
  assign selState = stageState[lvlSel];

  always_comb begin
    for (int i = 0; i < GROUP; i++) peMask[i] = (i < (GROUP >> lvlSel));
  end

  // R7: number of active elements halves per level
  a_r7_mask_count: assert property (@(posedge clk) disable iff (!rstN)
    $countones(peMask) == (GROUP >> lvlSel));

endmodule

// File: tb/cost_pyramid_acc_test.sv
module cost_pyramid_acc_test;
  localparam int W = 16, H = 16, S = 4, CW = 8, L = 4, OW = CW + 6;

  logic clk = 0, rstN = 0, inValid = 0;
  logic [CW-1:0] inCost = 0;
  logic [3:0] inCol = 0, inLine = 0;
  logic [1:0] inState = 0, lvlSel = 0;
  logic [L-1:0] lvlValid;
  logic [L-1:0][OW-1:0] lvlCost;
  logic selValid;
  logic [OW-1:0] selCost;
  logic [3:0] selCol, selLine;
  logic [1:0] selState;
  logic [7:0] peMask;

  int refc [L][H][W][S];
  int cnt [L];
  int checks = 0, fails = 0, cycles = 0;

  cost_pyramid_acc uut (.clk(clk), .rstN(rstN), .inValid(inValid), .inCost(inCost),
    .inCol(inCol), .inLine(inLine), .inState(inState), .lvlSel(lvlSel),
    .lvlValid(lvlValid), .lvlCost(lvlCost), .selValid(selValid), .selCost(selCost),
    .selCol(selCol), .selLine(selLine), .selState(selState), .peMask(peMask));

  always #2 clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int pick(int mode, int x, int y, int s);
    case (mode)
      1: return 255;
      2: return 0;
      3: return (x * 13 + y * 7 + s * 29) % 256;
      default: return $urandom % 256;
    endcase
  endfunction

  // monitor: compares every level stream with the reference pyramid
  always @(negedge clk) begin
    for (int k = 0; k < L; k++) begin
      if (lvlValid[k]) begin
        int w, s, x, y;
        w = W >> k;
        s = cnt[k] % S;
        x = (cnt[k] / S) % w;
        y = cnt[k] / (S * w);
        if (y < (H >> k))
          check(lvlCost[k] == OW'(refc[k][y][x][s]), k == 0 ? "R1 level0 cost" : "R2 block sum",
                int'(lvlCost[k]), refc[k][y][x][s]);
        else
          check(0, "R3 extra element", cnt[k], (W >> k) * (H >> k) * S);
        cnt[k]++;
      end
    end
    if (rstN) begin
      check(selValid == lvlValid[lvlSel], "R6 select valid", int'(selValid), int'(lvlValid[lvlSel]));
      if (selValid)
        check(selCost == OW'(refc[lvlSel][selLine][selCol][selState]), "R6 select cost/position",
              int'(selCost), refc[lvlSel][selLine][selCol][selState]);
    end
  end

  task automatic run_frame(input int mode, input int gapPct, input int sel);
    for (int y = 0; y < H; y++)
      for (int x = 0; x < W; x++)
        for (int s = 0; s < S; s++) refc[0][y][x][s] = pick(mode, x, y, s);
    for (int k = 1; k < L; k++)
      for (int y = 0; y < (H >> k); y++)
        for (int x = 0; x < (W >> k); x++)
          for (int s = 0; s < S; s++)
            refc[k][y][x][s] = refc[k-1][2*y][2*x][s] + refc[k-1][2*y][2*x+1][s]
                             + refc[k-1][2*y+1][2*x][s] + refc[k-1][2*y+1][2*x+1][s];
    @(negedge clk);
    lvlSel = 2'(sel);
    for (int k = 0; k < L; k++) cnt[k] = 0;
    @(negedge clk);
    check(peMask == 8'((1 << (8 >> sel)) - 1), "R7 active mask", int'(peMask), (1 << (8 >> sel)) - 1);
    for (int y = 0; y < H; y++)
      for (int x = 0; x < W; x++)
        for (int s = 0; s < S; s++) begin
          if (($urandom % 100) < gapPct) begin
            inValid = 0;
            inCost = 8'($urandom);   // R5: garbage on an idle cycle must be ignored
            @(negedge clk);
          end
          inValid = 1; inCost = 8'(refc[0][y][x][s]);
          inCol = 4'(x); inLine = 4'(y); inState = 2'(s);
          @(negedge clk);
        end
    inValid = 0;
    repeat (10) @(negedge clk);
    for (int k = 0; k < L; k++)
      check(cnt[k] == (W >> k) * (H >> k) * S, "R3 element count", cnt[k], (W >> k) * (H >> k) * S);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    check(lvlValid == '0 && selValid == 0, "R8 reset state", int'(lvlValid), 0);
    rstN = 1;
    @(negedge clk);
    check(lvlValid == '0, "R8 first cycle after reset", int'(lvlValid), 0);
    run_frame(0, 0, 0);    // R1 R2 dense random
    run_frame(1, 0, 3);    // R4 all ones, widest sums
    run_frame(0, 30, 1);   // R5 idle gaps
    run_frame(2, 10, 2);   // all zero
    run_frame(3, 20, 3);   // position ramp
    run_frame(0, 50, 2);   // R5 heavy gaps
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      fails++; checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule